// File: doc/BRIEF.md
# Two-Wire Bus State and Error Monitor

This block watches the clock and data lines of a two-wire (I2C) bus by sampling them with the system clock. It recognises START, repeated START and STOP conditions and keeps a two-bit record of who holds the bus. It raises a single-cycle error pulse when a START or STOP arrives where a well-formed transfer could not have one. It also raises a single-cycle pulse when this host's own controller loses arbitration. The controller that owns byte shifting and clock generation feeds the monitor its drive intents: whether it is issuing a START, whether it is driving a bit, and whether it currently releases the data line. It reads back the bus state and the two pulses.

Software can push the state back to idle by writing the idle code. Any other written code is ignored. While the monitor is disabled, the state stays unknown and no pulses are produced. A frame is nine clock pulses long: eight data bits plus one acknowledge bit. A START or STOP is well placed only on the clock pulse that follows a completed frame.

Top module: `i2c_bus_monitor`

## Requirements
- R1: The bus state encoding is 0 = unknown, 1 = idle, 2 = owned by this host, 3 = busy with another master. The state is 0 after reset and stays 0 after enabling until a bus condition is seen.
- R2: A START is SDA falling while SCL is high. A START seen while `hostStart` is low moves the state to 3.
- R3: A STOP is SDA rising while SCL is high, and it moves the state to 1.
- R4: A START seen while `hostStart` is high, and without arbitration loss, moves the state to 2.
- R5: A one-cycle `forceWrite` with `forceValue` = 1 sets the state to 1 and closes the open frame. With any other `forceValue`, the state is left unchanged.
- R6: A STOP that follows a START with no SCL rising edge between them produces exactly one `busError` pulse.
- R7: Inside an open frame, a START or STOP produces a `busError` pulse unless it occurs on the SCL pulse that follows a completed nine-pulse frame. A START or STOP in that position produces no pulse.
- R8: When the host releases SDA (`hostSdaOut` = 1) while `hostStart` or `hostActive` is high, and SDA is sampled low with SCL high, one `arbLost` pulse is produced and the state becomes 3. This covers arbitration loss during a START, a repeated START, a high data bit and a NACK bit.
- R9: While `enable` is low, the state is 0 and neither `busError` nor `arbLost` pulses.
- R10: `busError` and `arbLost` are single-cycle pulses. `arbLost` pulses once per onset of the losing condition, even if that condition persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SCL rate |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Monitor enable |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| hostStart | input | 1 | Host is attempting a START or repeated START |
| hostActive | input | 1 | Host is driving a data or acknowledge bit |
| hostSdaOut | input | 1 | Host SDA intent, 1 = released high |
| forceWrite | input | 1 | One-cycle software write to the state field |
| forceValue | input | 2 | Value written; only 1 has an effect |
| busState | output | 2 | Current bus state code |
| busError | output | 1 | One-cycle bus error pulse |
| arbLost | output | 1 | One-cycle arbitration lost pulse |

## Verification
Each bus condition passes through the synchroniser and edge-compare registers before it reaches the state register. As a result, a wrong frame position or a stale ownership value shows up at the ports about three clock cycles after the offending line edge. A wrong position appears as a missing or extra `busError` pulse. A wrong ownership value appears as a `busState` code that differs from the model. A lost arming bit in the arbitration logic shows up at once as a repeated `arbLost` pulse on a persisting condition. The bench steps one line or intent at a time and compares every step against a cycle-free model. Because of this, any divergence is caught at the first step where it matters.

// File: rtl/busmon_pkg.sv
package busmon_pkg;

  typedef enum logic [1:0] {
    BUS_UNKNOWN = 2'd0,
    BUS_IDLE    = 2'd1,
    BUS_OWNER   = 2'd2,
    BUS_BUSY    = 2'd3
  } busState_e;

  // datapath -> control
  typedef struct packed {
    logic sclHigh;
    logic sdaHigh;
    logic startSeen;
    logic stopSeen;
    logic atBoundary;
  } lineEvents_t;

  // control -> datapath
  typedef struct packed {
    logic frameRestart;
  } ctrlStrobes_t;

endpackage

// File: rtl/busmon_datapath.sv
module busmon_datapath
  import busmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_BITS   = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  ctrlStrobes_t strobes,
  output lineEvents_t  events
);

  localparam int FRAME_LEN = DATA_BITS + 1;
  localparam int POS_W     = $clog2(FRAME_LEN + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic sclRise;
  logic [POS_W-1:0] bitPos;
  logic byteDone;

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  // Lines reset to released so no edge appears when reset lifts.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync[0] <= sclIn;
      sdaSync[0] <= sdaIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclSync[i] <= sclSync[i-1];
        sdaSync[i] <= sdaSync[i-1];
      end
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclRise = sclNow && !sclPrev;

  // Position of the current SCL pulse inside a nine-pulse frame.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos   <= '0;
      byteDone <= 1'b0;
    end else if (strobes.frameRestart) begin
      bitPos   <= '0;
      byteDone <= 1'b0;
    end else if (sclRise) begin
      if (bitPos == POS_W'(FRAME_LEN)) bitPos <= POS_W'(1);
      else                             bitPos <= bitPos + 1'b1;
      if (bitPos == POS_W'(FRAME_LEN - 1)) byteDone <= 1'b1;
    end
  end

  always_comb begin
    events.sclHigh    = sclNow;
    events.sdaHigh    = sdaNow;
    events.startSeen  = sclNow && sclPrev && sdaPrev && !sdaNow;
    events.stopSeen   = sclNow && sclPrev && !sdaPrev && sdaNow;
    events.atBoundary = byteDone && (bitPos == POS_W'(1));
  end

  // R6
  restart_clears_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frameRestart |=> (bitPos == '0 && !byteDone));

  // R7
  pos_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitPos <= POS_W'(FRAME_LEN));

endmodule

// File: rtl/busmon_control.sv
module busmon_control
  import busmon_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         hostStart,
  input  logic         hostActive,
  input  logic         hostSdaOut,
  input  logic         forceWrite,
  input  logic [1:0]   forceValue,
  input  lineEvents_t  events,
  output ctrlStrobes_t strobes,
  output busState_e    stateQ,
  output logic         busErrorQ,
  output logic         arbLostQ
);

  logic forceIdle, arbCond, arbCondQ, arbEvt, errEvt, frameOpen;
  busState_e stateD;

  assign forceIdle = enable && forceWrite && (forceValue == BUS_IDLE);
  assign arbCond   = enable && (hostStart || hostActive) && hostSdaOut
                     && events.sclHigh && !events.sdaHigh;
  assign arbEvt    = arbCond && !arbCondQ;
  assign errEvt    = enable && frameOpen && (events.startSeen || events.stopSeen)
                     && !events.atBoundary;

  assign strobes.frameRestart = events.startSeen;

  always_comb begin
    stateD = stateQ;
    if (!enable)                stateD = BUS_UNKNOWN;
    else if (forceIdle)         stateD = BUS_IDLE;
    else if (arbEvt)            stateD = BUS_BUSY;
    else if (events.stopSeen)   stateD = BUS_IDLE;
    else if (events.startSeen)  stateD = hostStart ? BUS_OWNER : BUS_BUSY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= BUS_UNKNOWN;
      frameOpen <= 1'b0;
      arbCondQ  <= 1'b0;
      busErrorQ <= 1'b0;
      arbLostQ  <= 1'b0;
    end else begin
      stateQ    <= stateD;
      arbCondQ  <= arbCond;
      busErrorQ <= errEvt;
      arbLostQ  <= arbEvt;
      if (!enable || forceIdle || events.stopSeen) frameOpen <= 1'b0;
      else if (events.startSeen)                   frameOpen <= 1'b1;
    end
  end

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (stateQ == BUS_UNKNOWN && !busErrorQ && !arbLostQ));

  // R10
  arb_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    arbLostQ |=> !arbLostQ);

  // R8
  arb_to_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    arbLostQ |-> (stateQ == BUS_BUSY || $past(forceIdle)));

  // R5
  force_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    forceIdle |=> stateQ == BUS_IDLE);

  // R3
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (events.stopSeen && enable && !forceIdle && !arbEvt) |=> stateQ == BUS_IDLE);

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import busmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_BITS   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       hostStart,
  input  logic       hostActive,
  input  logic       hostSdaOut,
  input  logic       forceWrite,
  input  logic [1:0] forceValue,
  output logic [1:0] busState,
  output logic       busError,
  output logic       arbLost
);

  lineEvents_t  lineEvents;
  ctrlStrobes_t ctrlStrobes;
  busState_e    stateQ;

  busmon_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .DATA_BITS  (DATA_BITS)
  ) uDatapath (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .strobes(ctrlStrobes),
    .events (lineEvents)
  );

  busmon_control uControl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .hostStart (hostStart),
    .hostActive(hostActive),
    .hostSdaOut(hostSdaOut),
    .forceWrite(forceWrite),
    .forceValue(forceValue),
    .events    (lineEvents),
    .strobes   (ctrlStrobes),
    .stateQ    (stateQ),
    .busErrorQ (busError),
    .arbLostQ  (arbLost)
  );

  assign busState = stateQ;

endmodule

// File: tb/tb_i2c_bus_monitor.sv
`timescale 1ns/1ps
module tb_i2c_bus_monitor;

  localparam int HOLD  = 6;
  localparam int FRAME = 9;

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0;
  logic sclIn = 1'b1, sdaIn = 1'b1;
  logic hostStart = 1'b0, hostActive = 1'b0, hostSdaOut = 1'b1;
  logic forceWrite = 1'b0;
  logic [1:0] forceValue = 2'd0;
  logic [1:0] busState;
  logic busError, arbLost;

  int errCount = 0, chkCount = 0;
  int errPulses = 0, arbPulses = 0;
  int lastErr = 0, lastArb = 0;
  bit finished = 1'b0;

  // reference model of the requirements
  int mState = 0, mPos = 0;
  bit mFrame = 0, mDone = 0, mCond = 0;
  bit cScl = 1, cSda = 1, cEn = 0, cHs = 0, cHa = 0, cHo = 1;

  i2c_bus_monitor dut (
    .clk(clk), .rstN(rstN), .enable(enable), .sclIn(sclIn), .sdaIn(sdaIn),
    .hostStart(hostStart), .hostActive(hostActive), .hostSdaOut(hostSdaOut),
    .forceWrite(forceWrite), .forceValue(forceValue),
    .busState(busState), .busError(busError), .arbLost(arbLost)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (busError) errPulses <= errPulses + 1;
    if (arbLost)  arbPulses <= arbPulses + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    chkCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nextPos(input int pos);
    return (pos == FRAME) ? 1 : pos + 1;
  endfunction

  task automatic step(input bit nScl, input bit nSda, input bit nEn,
                      input bit nHs, input bit nHa, input bit nHo);
    int e0, a0;
    bit st, sp, rise, cond, arbE, errE;
    @(negedge clk);
    e0 = errPulses; a0 = arbPulses;
    sclIn = nScl; sdaIn = nSda; enable = nEn;
    hostStart = nHs; hostActive = nHa; hostSdaOut = nHo;
    repeat (HOLD) @(negedge clk);
    st   = cScl && nScl && cSda && !nSda;
    sp   = cScl && nScl && !cSda && nSda;
    rise = !cScl && nScl;
    cond = nEn && (nHs || nHa) && nHo && nScl && !nSda;
    arbE = cond && !mCond;
    mCond = cond;
    errE = nEn && mFrame && (st || sp) && !(mPos == 1 && mDone);
    if (!nEn)      mState = 0;
    else if (arbE) mState = 3;
    else if (sp)   mState = 1;
    else if (st)   mState = nHs ? 2 : 3;
    if (!nEn || sp) mFrame = 0;
    else if (st)    mFrame = 1;
    if (st) begin
      mPos = 0; mDone = 0;
    end else if (rise) begin
      mPos = nextPos(mPos);
      if (mPos == FRAME) mDone = 1;
    end
    cScl = nScl; cSda = nSda; cEn = nEn; cHs = nHs; cHa = nHa; cHo = nHo;
    lastErr = errPulses - e0;
    lastArb = arbPulses - a0;
    check("R1 R2 R3 R4 R8 R9 model state", int'(busState), mState);
    check("R6 R7 R9 R10 model busError", lastErr, int'(errE));
    check("R8 R9 R10 model arbLost", lastArb, int'(arbE));
  endtask

  task automatic lines(input bit s, input bit d);
    step(s, d, cEn, cHs, cHa, cHo);
  endtask

  task automatic host(input bit hs, input bit ha, input bit ho);
    step(cScl, cSda, cEn, hs, ha, ho);
  endtask

  task automatic setEn(input bit en);
    step(cScl, cSda, en, cHs, cHa, cHo);
  endtask

  task automatic forceStep(input logic [1:0] val);
    int e0, a0;
    @(negedge clk);
    e0 = errPulses; a0 = arbPulses;
    forceWrite = 1'b1; forceValue = val;
    @(negedge clk);
    forceWrite = 1'b0;
    repeat (HOLD) @(negedge clk);
    if (cEn && val == 2'd1) begin
      mState = 1; mFrame = 0;
    end
    lastErr = errPulses - e0;
    lastArb = arbPulses - a0;
    check("R5 model state after force", int'(busState), mState);
    check("R5 no pulse on force", lastErr + lastArb, 0);
  endtask

  // one full nine-pulse frame with SDA low, starting with SCL high
  task automatic clockFrame();
    for (int i = 0; i < FRAME; i++) begin
      lines(1'b0, cSda);
      lines(1'b1, cSda);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errCount++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errCount, chkCount + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1 reset state unknown", int'(busState), 0);
    check("R1 no pulses in reset", int'(busError) + int'(arbLost), 0);
    rstN = 1'b1;

    setEn(1'b1);
    check("R1 unknown after enable", int'(busState), 0);

    // START by another master, then STOP at once
    lines(1'b1, 1'b0);
    check("R2 foreign start gives busy", int'(busState), 3);
    lines(1'b1, 1'b1);
    check("R3 stop gives idle", int'(busState), 1);
    check("R6 start then stop is bus error", lastErr, 1);

    // host-issued START, full frame, well placed STOP
    host(1'b1, 1'b0, 1'b0);
    lines(1'b1, 1'b0);
    check("R4 host start gives owner", int'(busState), 2);
    host(1'b0, 1'b0, 1'b0);
    clockFrame();
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);
    check("R7 well placed stop no error", lastErr, 0);
    check("R3 stop after frame idle", int'(busState), 1);

    // misplaced STOP after one data pulse
    lines(1'b1, 1'b0);
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);
    check("R7 misplaced stop is bus error", lastErr, 1);

    // well placed repeated START after a frame
    lines(1'b1, 1'b0);
    clockFrame();
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    lines(1'b1, 1'b0);
    check("R7 well placed repeated start no error", lastErr, 0);
    check("R2 repeated start busy", int'(busState), 3);

    // arbitration loss on a high data bit, condition persists
    lines(1'b0, 1'b0);
    host(1'b0, 1'b1, 1'b1);
    lines(1'b1, 1'b0);
    check("R8 arb lost on high bit", lastArb, 1);
    check("R8 arb lost gives busy", int'(busState), 3);
    host(1'b0, 1'b1, 1'b1);
    check("R10 no repeated arb pulse", lastArb, 0);
    host(1'b0, 1'b0, 1'b1);

    // force writes
    forceStep(2'd2);
    check("R5 force value 2 ignored", int'(busState), 3);
    forceStep(2'd3);
    check("R5 force value 3 ignored", int'(busState), 3);
    forceStep(2'd1);
    check("R5 force value 1 gives idle", int'(busState), 1);

    // disabled: state unknown, no pulses
    lines(1'b1, 1'b1);
    setEn(1'b0);
    check("R9 disabled unknown", int'(busState), 0);
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);
    check("R9 disabled no error", lastErr, 0);
    check("R9 disabled state held", int'(busState), 0);
    host(1'b1, 1'b0, 1'b1);
    lines(1'b1, 1'b0);
    check("R9 disabled no arb", lastArb, 0);
    lines(1'b1, 1'b1);
    setEn(1'b1);

    // arbitration loss during a START attempt
    host(1'b1, 1'b0, 1'b1);
    lines(1'b1, 1'b0);
    check("R8 arb lost during start", lastArb, 1);
    check("R8 busy after lost start", int'(busState), 3);
    host(1'b0, 1'b0, 1'b1);
    lines(1'b1, 1'b1);

    // constrained random walk
    for (int n = 0; n < 500; n++) begin
      int r;
      r = $urandom % 20;
      if (r < 8)       lines(!cScl, cSda);
      else if (r < 14) lines(cScl, !cSda);
      else if (r < 18) host(1'($urandom), 1'($urandom), 1'($urandom));
      else if (r == 18) forceStep(2'($urandom));
      else if ($urandom % 4 == 0) setEn(!cEn);
      else lines(!cScl, cSda);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

endmodule